// File: doc/BRIEF.md
# Page Buffer Write-Cycle Controller

This block sits between a serial bus protocol engine and a 256-byte storage array. The protocol engine hands it one strobe per received data byte, a strobe when a new START is seen, and a strobe when the transfer ends with STOP. Data bytes are gathered into an eight-byte page buffer. Each slot has its own valid flag, so a transfer may fill any subset of the page.

On the STOP that closes a write transfer, the block opens a self-timed write window of a fixed number of clock cycles. It holds `busy` high for the whole window. On the final cycle of the window it pulses one write enable per loaded slot, and the array takes the new bytes. Each written byte fully replaces the old cell value, which stands in for the automatic erase-then-program step. A write-protect level vetoes the whole commit. An address-only transfer or an aborted transfer leaves the array untouched. Reads go straight to the array and are refused while a write window is open.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset, `busy`, `rd_valid` and every bit of `arr_we` are 0, and every array byte reads back as 0x00.
- R2: After a committed transfer, only the page slots that received a byte hold new data. The other bytes of that page keep their previous values.
- R3: The buffer slot is the low 3 bits of `wr_addr`, so addresses wrap within the page. A later byte aimed at an already loaded slot replaces the earlier byte.
- R4: With `wp` low and at least one slot loaded, a `stop_stb` sets `busy` from the next cycle for exactly `WR_CYCLES` consecutive cycles.
- R5: While `busy` is high, `wr_stb`, `stop_stb`, `start_stb` and `rd_en` have no effect: no byte is loaded, no second window starts, and `rd_valid` stays 0.
- R6: With `wp` high, `stop_stb` starts no window, the array is unchanged, and the loaded bytes are discarded.
- R7: A `stop_stb` with no slot loaded (an address-only transfer) does not raise `busy`.
- R8: A `start_stb` before `stop_stb` discards all loaded bytes, so the following `stop_stb` does not raise `busy`.
- R9: When a window ends, the buffer and its valid flags are empty, so a bare `stop_stb` right after it starts no window.
- R10: `arr_we` is non-zero only in the last cycle of a window. In that cycle bit i is 1 exactly when slot i was loaded, and `arr_page` gives the page number (address bits 7..3).
- R11: When `rd_en` is high and `busy` is low, `rd_valid` is 1 in the next cycle and `rd_data` then holds the array byte at `rd_addr`.
- R12: The page number is taken from the first byte of a transfer. The upper address bits of later bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One data byte received |
| wr_addr | input | 8 | Word address of the byte |
| wr_data | input | 8 | Byte value |
| start_stb | input | 1 | START seen on the bus; aborts a pending transfer |
| stop_stb | input | 1 | STOP seen on the bus; requests commit |
| wp | input | 1 | Write-protect level, high blocks commits |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| busy | output | 1 | Write window open |
| arr_we | output | 8 | Per-slot array write enables |
| arr_page | output | 5 | Page targeted by `arr_we` |

## Verification
The hardest case to reach is bus activity that lands inside an open write window. The stimulus has to raise a byte strobe, a STOP, a START and a read in the middle of the window, then prove that none of them changed anything. Afterwards the bench shows that the window length is unchanged, that no second window follows, that the poked address still reads its old value, and that a bare STOP starts nothing. Write protection and aborted transfers are checked the same way, by reading the page back through the normal read port.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int PAGE_BYTES = 8;
    localparam int SLOT_W     = $clog2(PAGE_BYTES);
    localparam int PAGE_W     = ADDR_W - SLOT_W;
    localparam int WORDS      = 1 << ADDR_W;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [SLOT_W-1:0] slot;
    } waddr_t;

    typedef logic [PAGE_BYTES-1:0][DATA_W-1:0] page_data_t;
    typedef logic [PAGE_BYTES-1:0]             slot_mask_t;

    function automatic waddr_t split_addr(input logic [ADDR_W-1:0] a);
        return waddr_t'(a);
    endfunction
endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf
    import pgw_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  waddr_t                 load_addr,
    input  logic [DATA_W-1:0]      load_data,
    input  logic                   flush,
    output logic [PAGE_W-1:0]      page,
    output slot_mask_t             filled,
    output page_data_t             bytes
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            filled <= '0;
            page   <= '0;
            bytes  <= '0;
        end else if (load) begin
            if (filled == '0)
                page <= load_addr.page;
            filled[load_addr.slot] <= 1'b1;
            bytes[load_addr.slot]  <= load_data;
        end
    end
endmodule

// File: rtl/pgw_cycle_timer.sv
module pgw_cycle_timer #(
    parameter int WR_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic busy,
    output logic last
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    logic [CNT_W-1:0] remain;

    assign last = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (!busy) begin
            if (launch) begin
                busy   <= 1'b1;
                remain <= CNT_W'(WR_CYCLES - 1);
            end
        end else if (remain == '0) begin
            busy <= 1'b0;
        end else begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/pgw_store.sv
module pgw_store
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  slot_mask_t        we,
    input  logic [PAGE_W-1:0] page,
    input  page_data_t        wbytes,
    input  logic              rd_go,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++)
                cells[i] <= '0;
            rd_data <= '0;
        end else begin
            for (int s = 0; s < PAGE_BYTES; s++)
                if (we[s])
                    cells[{page, SLOT_W'(s)}] <= wbytes[s];
            if (rd_go)
                rd_data <= cells[rd_addr];
        end
    end
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit
    import pgw_pkg::*;
#(
    parameter int WR_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start_stb,
    input  logic              stop_stb,
    input  logic              wp,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic [PAGE_BYTES-1:0] arr_we,
    output logic [PAGE_W-1:0] arr_page
);
    slot_mask_t        filled;
    page_data_t        bytes;
    logic [PAGE_W-1:0] buf_page;
    logic              last;
    logic              idle, load, launch, flush, rd_go;

    assign idle   = !busy;
    assign load   = idle && wr_stb;
    assign launch = idle && stop_stb && !wp && (filled != '0);
    assign flush  = last || (idle && start_stb) || (idle && stop_stb && wp);
    assign rd_go  = idle && rd_en;

    assign arr_we   = last ? filled : '0;
    assign arr_page = buf_page;

    pgw_page_buf u_buf (
        .clk(clk), .rst(rst), .load(load),
        .load_addr(split_addr(wr_addr)), .load_data(wr_data),
        .flush(flush), .page(buf_page), .filled(filled), .bytes(bytes)
    );

    pgw_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .launch(launch), .busy(busy), .last(last)
    );

    pgw_store u_store (
        .clk(clk), .rst(rst), .we(arr_we), .page(buf_page), .wbytes(bytes),
        .rd_go(rd_go), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= rd_go;
    end
endmodule

// File: rtl/pgbuf_commit_chk.sv
module pgbuf_commit_chk #(
    parameter int PB = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic [PB-1:0] arr_we,
    input logic          stop_stb,
    input logic          wp,
    input logic          rd_en,
    input logic          rd_valid
);
    // R10
    we_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        (|arr_we) |-> busy);
    // R10
    we_closes_window_chk: assert property (@(posedge clk) disable iff (rst)
        (|arr_we) |=> !busy);
    // R4
    window_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !(|arr_we)) |=> busy);
    // R6
    window_needs_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(stop_stb) && !$past(wp)));
    // R11
    read_answers_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !busy) |=> rd_valid);
    // R5
    read_refused_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !rd_valid);
endmodule

bind pgbuf_commit pgbuf_commit_chk #(.PB(pgw_pkg::PAGE_BYTES)) chk_i (
    .clk(clk), .rst(rst), .busy(busy), .arr_we(arr_we), .stop_stb(stop_stb),
    .wp(wp), .rd_en(rd_en), .rd_valid(rd_valid)
);

// File: tb/pgbuf_commit_tb_top.sv
module pgbuf_commit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WCYC       = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 0, start_stb = 0, stop_stb = 0, wp = 0, rd_en = 0;
    logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
    logic [7:0] rd_data;
    logic       rd_valid, busy;
    logic [7:0] arr_we;
    logic [4:0] arr_page;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] ref_mem [256];
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] pend_d [8];
    logic [7:0] pend_v;
    logic [4:0] pend_p;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgbuf_commit #(.WR_CYCLES(WCYC)) dut_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .start_stb(start_stb), .stop_stb(stop_stb), .wp(wp), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .arr_we(arr_we), .arr_page(arr_page)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) chk(0, "R11 unexpected rd_valid", 1, 0);
            else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(rd_data == e, t, rd_data, e);
            end
        end
    end

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        wr_stb = 1; wr_addr = a; wr_data = d;
        if (pend_v == 0) pend_p = a[7:3];
        pend_v[a[2:0]] = 1'b1; pend_d[a[2:0]] = d;
        @(negedge clk);
        wr_stb = 0;
    endtask

    task automatic pulse_stop();
        stop_stb = 1; @(negedge clk); stop_stb = 0;
    endtask

    task automatic pulse_start();
        start_stb = 1; @(negedge clk); start_stb = 0;
        pend_v = 0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        rd_en = 1; rd_addr = a;
        exp_q.push_back(ref_mem[a]); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic expect_idle(input string tag);
        for (int i = 0; i < 3; i++) begin
            chk(busy == 0 && arr_we == 0, tag, {busy, arr_we}, 0);
            @(negedge clk);
        end
        pend_v = 0;
    endtask

    // call right after pulse_stop; follows the whole window
    task automatic run_window(input bit poke);
        int n = 0, seen = 0;
        chk(busy == 1, "R4 busy after stop", busy, 1);
        while (busy && n < WCYC + 5) begin
            if (arr_we != 0) begin
                seen++;
                chk(arr_we == pend_v, "R10 write mask", arr_we, pend_v);
                chk(arr_page == pend_p, "R10 page", arr_page, pend_p);
                chk(n == WCYC - 1, "R10 last cycle", n, WCYC - 1);
            end
            if (poke && n == 2) begin
                wr_stb = 1; wr_addr = 8'h51; wr_data = 8'hEE;
                stop_stb = 1; start_stb = 1; rd_en = 1; rd_addr = 8'h50;
            end
            if (poke && n == 3) begin
                wr_stb = 0; stop_stb = 0; start_stb = 0; rd_en = 0;
                chk(rd_valid == 0, "R5 read refused", rd_valid, 0);
            end
            n++;
            @(negedge clk);
        end
        chk(n == WCYC, "R4 window length", n, WCYC);
        chk(seen == 1, "R10 single enable pulse", seen, 1);
        for (int s = 0; s < 8; s++)
            if (pend_v[s]) ref_mem[{pend_p, 3'(s)}] = pend_d[s];
        pend_v = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        pend_v = 0; pend_p = 0;
        for (int i = 0; i < 8; i++) pend_d[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(busy == 0 && rd_valid == 0 && arr_we == 0, "R1 reset outputs",
            {busy, rd_valid, arr_we}, 0);
        rd(8'hFF, "R1 array cleared");

        // R2 partial page
        wr_byte(8'h41, 8'hAA); wr_byte(8'h43, 8'hBB); wr_byte(8'h46, 8'hCC);
        pulse_stop(); run_window(0);
        for (int a = 8'h40; a < 8'h48; a++) rd(8'(a), "R2 partial page");
        // R11 back-to-back read latency
        rd(8'h43, "R11 read data");

        // R3 wrap and replace
        wr_byte(8'h85, 8'h11); wr_byte(8'h86, 8'h22); wr_byte(8'h87, 8'h33);
        wr_byte(8'h80, 8'h44); wr_byte(8'h86, 8'h55);
        pulse_stop(); run_window(0);
        for (int a = 8'h80; a < 8'h88; a++) rd(8'(a), "R3 wrap replace");

        // R12 page from first byte
        wr_byte(8'h20, 8'h9A); wr_byte(8'h3F, 8'h5C);
        pulse_stop(); run_window(0);
        rd(8'h27, "R12 slot on first page"); rd(8'h3F, "R12 other page untouched");
        rd(8'h20, "R12 first byte");

        // R5 pokes during window
        wr_byte(8'h50, 8'h77);
        pulse_stop(); run_window(1);
        expect_idle("R5 no second window");
        rd(8'h51, "R5 write ignored"); rd(8'h50, "R5 committed byte");
        // R9 buffer empty after commit
        pulse_stop(); expect_idle("R9 buffer cleared");

        // R6 write protect
        wp = 1;
        wr_byte(8'h60, 8'h12); pulse_stop(); expect_idle("R6 protected");
        wp = 0;
        pulse_stop(); expect_idle("R6 bytes discarded");
        rd(8'h60, "R6 array unchanged");

        // R7 address-only transfer
        pulse_start(); pulse_stop(); expect_idle("R7 dummy write");

        // R8 abort by START
        wr_byte(8'h70, 8'hAB); pulse_start(); pulse_stop(); expect_idle("R8 aborted");
        wr_byte(8'h71, 8'hCD); pulse_stop(); run_window(0);
        rd(8'h70, "R8 aborted byte absent"); rd(8'h71, "R8 later transfer");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule